// File: doc/BRIEF.md
# Register-memory move/add processor core

This block is a small multi-cycle processor with four 16-bit general-purpose registers and a program counter. Every instruction has two operands. Each operand can name either a register or a word of a unified, word-addressed internal memory. The core supports two operations, copy and add, and any other opcode executes as a no-operation. The program counter can be read and written like any other register. A program ends itself by writing a value into the program counter that lies past the end of memory.

The memory is filled through a valid/ready load port while the core is idle, and a start pulse launches execution from word 0. After the core halts, the memory words and registers can be read through debug ports, and `halted` stays high until the next start or reset. The load port applies back-pressure for the whole of a run. `ld_ready` is low from the cycle after an accepted start until the core halts. A beat transfers only on a cycle where `ld_valid` and `ld_ready` are both high. The producer must hold its address and data while it waits.

Top module: `regmem_core`

## Requirements
- R1: An instruction is three consecutive memory words at the program counter: opcode at pc, destination operand at pc+1, source operand at pc+2.
- R2: Opcode 0 (copy) writes the value named by the source operand into the location named by the destination operand.
- R3: Opcode 1 (add) writes the destination value plus the source value, taken modulo 2^16, back into the destination. Both values are read before the write.
- R4: An operand with bit 15 set names the memory word at its low 15 bits. Words at or above MEM_WORDS read as zero, and writes to them are dropped.
- R5: An operand with bit 15 clear is a register index: 0..3 are the general-purpose registers and 4 is the program counter. Indices 5 and above read as zero, and writes to them are dropped.
- R6: After every instruction the program counter advances by 3, including after an instruction that wrote the program counter.
- R7: The core halts when the advanced program counter, computed without 16-bit wrap, is at least MEM_WORDS. `halted` then stays high until reset or the next accepted start.
- R8: Opcodes other than 0 and 1 change no register and no memory word.
- R9: `ld_ready` is high exactly while the core is not running. A word is written on `ld_valid && ld_ready`. Load addresses at or above MEM_WORDS are dropped. Load beats offered while the core is running have no effect.
- R10: After reset `halted` is 0 and `ld_ready` is 1. A start pulse is accepted only while idle. It clears all registers and `halted` and begins fetching at word 0. A start pulse while running is ignored.
- R11: `dbg_mem_data` shows the memory word addressed by `dbg_mem_addr` one clock later. `dbg_reg_data` shows register `dbg_reg_idx` in the same cycle, and indices 5 to 7 read as zero.
- R12: Each instruction takes 7 cycles. `halted` rises 7*N clock edges after the edge that accepts start, where N is the number of instructions executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that starts a program from word 0 |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Core idle; load beat accepted |
| ld_addr | input | 16 | Memory word address of the load beat |
| ld_data | input | 16 | Data of the load beat |
| dbg_mem_addr | input | 16 | Debug memory read address |
| dbg_mem_data | output | 16 | Debug memory read data, one cycle after the address |
| dbg_reg_idx | input | 3 | Debug register index (4 = program counter) |
| dbg_reg_data | output | 16 | Debug register value, same cycle |
| halted | output | 1 | Program finished; held until reset or start |

## Verification
The assertions watch four things on every cycle: the program-counter step of 3 at each instruction boundary, the halt that must follow an out-of-range step, the stickiness of `halted`, and the relation between `halted`, `ld_ready` and an accepted start. Operand decoding, the copy and add results, wrap-around, the dropped out-of-range accesses and the no-operation opcodes cannot be seen from a single cycle. The bench shows them instead. It sweeps opcodes and operand pairs, runs an instruction-level model of each program, and compares every memory word, every register and the cycle count at halt.

// File: rtl/regmem_pkg.sv
package regmem_pkg;
  localparam int DW          = 16;
  localparam int IDXW        = DW - 1;
  localparam int NREG        = 5;
  localparam int PC_IDX      = 4;
  localparam int INSTR_WORDS = 3;

  localparam logic [DW-1:0] OP_MOVE = 16'd0;
  localparam logic [DW-1:0] OP_ADD  = 16'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP,
    ST_A1,
    ST_A2,
    ST_V1,
    ST_V2,
    ST_EX,
    ST_ADV
  } core_st_e;
endpackage

// File: rtl/regmem_ram.sv
module regmem_ram
  import regmem_pkg::*;
#(
  parameter int WORDS = 1024
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [DW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [DW:0] LIMIT = (DW+1)'(WORDS);

  logic [DW-1:0] store [WORDS];

  // write port: out-of-range addresses are dropped
  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < LIMIT)) begin
      store[waddr[AW-1:0]] <= wdata;
    end
  end

  // two registered read ports; out-of-range reads give zero
  logic [DW-1:0] raddr_v [2];
  logic [DW-1:0] rdata_v [2];
  assign raddr_v[0] = ra_addr;
  assign raddr_v[1] = rb_addr;

  for (genvar p = 0; p < 2; p++) begin : g_rport
    always_ff @(posedge clk) begin
      if ({1'b0, raddr_v[p]} < LIMIT) begin
        rdata_v[p] <= store[raddr_v[p][AW-1:0]];
      end else begin
        rdata_v[p] <= '0;
      end
    end
  end

  assign ra_data = rdata_v[0];
  assign rb_data = rdata_v[1];
endmodule

// File: rtl/regmem_regs.sv
module regmem_regs
  import regmem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            pc_adv,
  input  logic [IDXW-1:0] rd1_idx,
  output logic [DW-1:0]   rd1_data,
  input  logic [IDXW-1:0] rd2_idx,
  output logic [DW-1:0]   rd2_data,
  input  logic [2:0]      dbg_idx,
  output logic [DW-1:0]   dbg_data,
  output logic [DW-1:0]   pc
);
  logic [DW-1:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == PC_IDX) begin : g_pc
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          bank[i] <= '0;
        end else if (wr_en && (wr_idx == IDXW'(i))) begin
          bank[i] <= wr_data;
        end else if (pc_adv) begin
          bank[i] <= bank[i] + DW'(INSTR_WORDS);
        end
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          bank[i] <= '0;
        end else if (wr_en && (wr_idx == IDXW'(i))) begin
          bank[i] <= wr_data;
        end
      end
    end
  end

  // read muxes: indices past the bank read as zero
  always_comb begin
    rd1_data = '0;
    rd2_data = '0;
    dbg_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd1_idx == IDXW'(k)) rd1_data = bank[k];
      if (rd2_idx == IDXW'(k)) rd2_data = bank[k];
      if (dbg_idx == 3'(k))    dbg_data = bank[k];
    end
  end

  assign pc = bank[PC_IDX];
endmodule

// File: rtl/regmem_ctrl.sv
module regmem_ctrl
  import regmem_pkg::*;
#(
  parameter int WORDS = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   mem_raddr,
  output logic            mem_we,
  output logic [DW-1:0]   mem_waddr,
  output logic [DW-1:0]   mem_wdata,
  output logic [IDXW-1:0] rd1_idx,
  input  logic [DW-1:0]   rd1_data,
  output logic [IDXW-1:0] rd2_idx,
  input  logic [DW-1:0]   rd2_data,
  output logic            reg_we,
  output logic [IDXW-1:0] reg_widx,
  output logic [DW-1:0]   reg_wdata,
  input  logic [DW-1:0]   pc,
  output logic            pc_adv,
  output logic            rf_clr,
  output logic            busy,
  output logic            halted
);
  localparam logic [DW:0] LIMIT = (DW+1)'(WORDS);

  core_st_e      state_q, state_d;
  logic [DW-1:0] op_q, a1_q, a2_q, v1_q;
  logic          halted_q;

  logic [DW-1:0] v1, v2, result;
  logic          do_write;
  logic [DW:0]   pc_next_wide;

  // operand values: memory word from the read port, or register
  assign rd1_idx = a1_q[IDXW-1:0];
  assign rd2_idx = a2_q[IDXW-1:0];
  assign v1 = a1_q[DW-1] ? mem_rdata : rd1_data;
  assign v2 = a2_q[DW-1] ? mem_rdata : rd2_data;

  always_comb begin
    do_write = 1'b1;
    result   = v2;
    unique case (op_q)
      OP_MOVE: result = v2;
      OP_ADD:  result = v1_q + v2;
      default: do_write = 1'b0;
    endcase
  end

  // read address schedule
  always_comb begin
    unique case (state_q)
      ST_A1:   mem_raddr = pc + DW'(1);
      ST_A2:   mem_raddr = pc + DW'(2);
      ST_V1:   mem_raddr = {1'b0, a1_q[IDXW-1:0]};
      ST_V2:   mem_raddr = {1'b0, a2_q[IDXW-1:0]};
      default: mem_raddr = pc;
    endcase
  end

  assign mem_we    = (state_q == ST_EX) && do_write && a1_q[DW-1];
  assign mem_waddr = {1'b0, a1_q[IDXW-1:0]};
  assign mem_wdata = result;
  assign reg_we    = (state_q == ST_EX) && do_write && !a1_q[DW-1];
  assign reg_widx  = a1_q[IDXW-1:0];
  assign reg_wdata = result;

  assign pc_adv       = (state_q == ST_ADV);
  assign pc_next_wide = {1'b0, pc} + (DW+1)'(INSTR_WORDS);
  assign rf_clr       = (state_q == ST_IDLE) && start;
  assign busy         = (state_q != ST_IDLE);
  assign halted       = halted_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_OP;
      ST_OP:   state_d = ST_A1;
      ST_A1:   state_d = ST_A2;
      ST_A2:   state_d = ST_V1;
      ST_V1:   state_d = ST_V2;
      ST_V2:   state_d = ST_EX;
      ST_EX:   state_d = ST_ADV;
      ST_ADV:  state_d = (pc_next_wide >= LIMIT) ? ST_IDLE : ST_OP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      halted_q <= 1'b0;
      op_q     <= '0;
      a1_q     <= '0;
      a2_q     <= '0;
      v1_q     <= '0;
    end else begin
      state_q <= state_d;
      if (rf_clr) begin
        halted_q <= 1'b0;
      end else if (pc_adv && (pc_next_wide >= LIMIT)) begin
        halted_q <= 1'b1;
      end
      if (state_q == ST_A1) op_q <= mem_rdata;
      if (state_q == ST_A2) a1_q <= mem_rdata;
      if (state_q == ST_V1) a2_q <= mem_rdata;
      if (state_q == ST_V2) v1_q <= v1;
    end
  end
endmodule

// File: rtl/regmem_core.sv
module regmem_core
  import regmem_pkg::*;
#(
  parameter int MEM_WORDS = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [15:0]   ld_addr,
  input  logic [15:0]   ld_data,
  input  logic [15:0]   dbg_mem_addr,
  output logic [15:0]   dbg_mem_data,
  input  logic [2:0]    dbg_reg_idx,
  output logic [15:0]   dbg_reg_data,
  output logic          halted
);
  logic [DW-1:0]   mem_rdata, mem_raddr, core_waddr, core_wdata;
  logic            core_we, busy;
  logic [IDXW-1:0] rd1_idx, rd2_idx, reg_widx;
  logic [DW-1:0]   rd1_data, rd2_data, reg_wdata;
  logic            reg_we, pc_adv, rf_clr;
  logic [DW-1:0]   pc_q;

  logic            ram_we;
  logic [DW-1:0]   ram_waddr, ram_wdata;
  logic            ld_fire;

  assign ld_ready  = !busy;
  assign ld_fire   = ld_valid && ld_ready;
  assign ram_we    = core_we || ld_fire;
  assign ram_waddr = core_we ? core_waddr : ld_addr;
  assign ram_wdata = core_we ? core_wdata : ld_data;

  regmem_ram #(.WORDS(MEM_WORDS)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .ra_addr (mem_raddr),
    .ra_data (mem_rdata),
    .rb_addr (dbg_mem_addr),
    .rb_data (dbg_mem_data)
  );

  regmem_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rf_clr),
    .wr_en    (reg_we),
    .wr_idx   (reg_widx),
    .wr_data  (reg_wdata),
    .pc_adv   (pc_adv),
    .rd1_idx  (rd1_idx),
    .rd1_data (rd1_data),
    .rd2_idx  (rd2_idx),
    .rd2_data (rd2_data),
    .dbg_idx  (dbg_reg_idx),
    .dbg_data (dbg_reg_data),
    .pc       (pc_q)
  );

  regmem_ctrl #(.WORDS(MEM_WORDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_rdata (mem_rdata),
    .mem_raddr (mem_raddr),
    .mem_we    (core_we),
    .mem_waddr (core_waddr),
    .mem_wdata (core_wdata),
    .rd1_idx   (rd1_idx),
    .rd1_data  (rd1_data),
    .rd2_idx   (rd2_idx),
    .rd2_data  (rd2_data),
    .reg_we    (reg_we),
    .reg_widx  (reg_widx),
    .reg_wdata (reg_wdata),
    .pc        (pc_q),
    .pc_adv    (pc_adv),
    .rf_clr    (rf_clr),
    .busy      (busy),
    .halted    (halted)
  );
endmodule

// File: rtl/regmem_core_chk.sv
module regmem_core_chk #(
  parameter int WORDS = 1024
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        ld_ready,
  input logic        halted,
  input logic [15:0] pc,
  input logic        pc_adv
);
  localparam logic [16:0] LIMIT = 17'(WORDS);

  // R6: instruction boundary steps the program counter by three
  a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |=> (pc == $past(pc) + 16'd3));

  // R7: a step that leaves memory must end in halt
  a_r7_halt_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_adv && (({1'b0, pc} + 17'd3) >= LIMIT)) |=> halted);

  // R7: halted is held until a start arrives
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> halted);

  // R10: an accepted start clears halted and begins a run
  a_r10_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ld_ready) |=> (!halted && !ld_ready));

  // R9: a halted core accepts loads
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> ld_ready);
endmodule

bind regmem_core regmem_core_chk #(.WORDS(MEM_WORDS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ld_ready (ld_ready),
  .halted   (halted),
  .pc       (pc_q),
  .pc_adv   (pc_adv)
);

// File: tb/regmem_core_bench.sv
`timescale 1ns/1ps
module regmem_core_bench;
  localparam int MW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [15:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] dbg_mem_addr = '0;
  logic [15:0] dbg_mem_data;
  logic [2:0]  dbg_reg_idx = '0;
  logic [15:0] dbg_reg_data;
  logic        halted;

  always #2 clk = ~clk;

  regmem_core #(.MEM_WORDS(MW)) u_regmem_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .ld_valid     (ld_valid),
    .ld_ready     (ld_ready),
    .ld_addr      (ld_addr),
    .ld_data      (ld_data),
    .dbg_mem_addr (dbg_mem_addr),
    .dbg_mem_data (dbg_mem_data),
    .dbg_reg_idx  (dbg_reg_idx),
    .dbg_reg_data (dbg_reg_data),
    .halted       (halted)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] img  [MW];
  logic [15:0] mm   [MW];
  logic [15:0] mreg [5];
  int          msteps;
  bit          mhang;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- instruction-level model ----------------
  function automatic logic [15:0] mword(input int a);
    return (a < MW) ? mm[a] : 16'h0;
  endfunction

  function automatic logic [15:0] mget(input logic [15:0] a);
    if (a[15]) return mword(int'(a[14:0]));
    return (a[14:0] < 15'd5) ? mreg[a[2:0]] : 16'h0;
  endfunction

  task automatic mset(input logic [15:0] a, input logic [15:0] v);
    if (a[15]) begin
      if (int'(a[14:0]) < MW) mm[a[14:0]] = v;
    end else if (a[14:0] < 15'd5) begin
      mreg[a[2:0]] = v;
    end
  endtask

  task automatic model_run();
    logic [15:0] op, a1, a2, v1, v2;
    logic [16:0] nxt;
    bit done;
    for (int i = 0; i < MW; i++) mm[i] = img[i];
    for (int i = 0; i < 5; i++) mreg[i] = '0;
    msteps = 0;
    mhang  = 0;
    done   = 0;
    while (!done) begin
      if (msteps >= 200) begin
        mhang = 1;
        done  = 1;
      end else begin
        op = mword(int'(mreg[4]));
        a1 = mword(int'(mreg[4]) + 1);
        a2 = mword(int'(mreg[4]) + 2);
        v1 = mget(a1);
        v2 = mget(a2);
        if (op == 16'd0) mset(a1, v2);
        else if (op == 16'd1) mset(a1, v1 + v2);
        nxt = {1'b0, mreg[4]} + 17'd3;
        mreg[4] = nxt[15:0];
        msteps++;
        if (nxt >= 17'(MW)) done = 1;
      end
    end
  endtask

  // ---------------- DUT drivers ----------------
  task automatic load_image();
    for (int i = 0; i < MW; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = 16'(i);
      ld_data  = img[i];
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_dut(input bit poke, output int cycles);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    cycles = 0;
    do begin
      if (poke && cycles == 3) begin
        @(negedge clk);
        // R9: load beat and start offered mid-run
        check(ld_ready == 1'b0, "R9", "ld_ready while running", int'(ld_ready), 0);
        ld_valid = 1'b1;
        ld_addr  = 16'd60;
        ld_data  = 16'hBEEF;
        start    = 1'b1;
      end
      @(posedge clk);
      cycles++;
      #1;
      ld_valid = 1'b0;
      start    = 1'b0;
    end while (!halted && cycles < 3000);
  endtask

  task automatic compare_all(input string tag, input int cycles);
    check(cycles == 7 * msteps, "R12", {tag, " cycles to halt"}, cycles, 7 * msteps);
    check(halted == 1'b1, "R7", {tag, " halted"}, int'(halted), 1);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      dbg_reg_idx = 3'(r);
      #1;
      check(dbg_reg_data == ((r < 5) ? mreg[r] : 16'h0), "R11",
            $sformatf("%s reg %0d", tag, r), int'(dbg_reg_data),
            int'((r < 5) ? mreg[r] : 16'h0));
    end
    for (int a = 0; a < MW; a++) begin
      @(negedge clk);
      dbg_mem_addr = 16'(a);
      @(posedge clk);
      #1;
      check(dbg_mem_data == mm[a], "R11",
            $sformatf("%s mem %0d", tag, a), int'(dbg_mem_data), int'(mm[a]));
    end
  endtask

  task automatic run_case(input string tag, input bit poke);
    int cyc;
    model_run();
    if (!mhang) begin
      load_image();
      run_dut(poke, cyc);
      compare_all(tag, cyc);
    end
  endtask

  // skeleton: fill r0..r3, one operation at word 12, dump registers, exit
  task automatic build_sweep(input logic [15:0] op, input logic [15:0] d,
                             input logic [15:0] s);
    for (int i = 0; i < MW; i++) img[i] = '0;
    for (int r = 0; r < 4; r++) begin
      img[3*r] = 16'd0; img[3*r+1] = 16'(r); img[3*r+2] = 16'h8000 | 16'(40 + r);
    end
    img[12] = op; img[13] = d; img[14] = s;
    for (int r = 0; r < 4; r++) begin
      img[15+3*r] = 16'd0; img[16+3*r] = 16'h8000 | 16'(50 + r); img[17+3*r] = 16'(r);
    end
    img[27] = 16'd0; img[28] = 16'd4; img[29] = 16'h8000 | 16'd44;
    img[40] = 16'hFFF0; img[41] = 16'h0025; img[42] = 16'h8001;
    img[43] = 16'h7FFF; img[44] = 16'd1000;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] opl [4];
    logic [15:0] opnd [6];
    opl[0] = 16'd0; opl[1] = 16'd1; opl[2] = 16'd3; opl[3] = 16'hFFFF;
    opnd[0] = 16'h0001; opnd[1] = 16'h0004; opnd[2] = 16'h0006;
    opnd[3] = 16'h8000 | 16'd40; opnd[4] = 16'h8000 | 16'd63; opnd[5] = 16'h8000 | 16'd100;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10: reset state
    check(halted == 1'b0, "R10", "halted after reset", int'(halted), 0);
    check(ld_ready == 1'b1, "R10", "ld_ready after reset", int'(ld_ready), 1);

    // R1 R2 R3: two-number sum program, with a mid-run load/start poke (R9)
    for (int i = 0; i < MW; i++) img[i] = '0;
    img[0]  = 16'd0; img[1]  = 16'd0;      img[2]  = 16'h800F;
    img[3]  = 16'd0; img[4]  = 16'd1;      img[5]  = 16'h8010;
    img[6]  = 16'd1; img[7]  = 16'd0;      img[8]  = 16'd1;
    img[9]  = 16'd0; img[10] = 16'h8011;   img[11] = 16'd0;
    img[12] = 16'd0; img[13] = 16'd4;      img[14] = 16'h8012;
    img[15] = 16'd40; img[16] = 16'd2; img[17] = 16'd0; img[18] = 16'd1000;
    run_case("R1 sum", 1'b1);
    check(mm[17] == 16'd42, "R3", "model sum", int'(mm[17]), 42);
    repeat (10) @(posedge clk);
    #1 check(halted == 1'b1, "R7", "halted held", int'(halted), 1);

    // R7: exit through a program counter near 2^16 must not wrap back
    for (int i = 0; i < MW; i++) img[i] = '0;
    img[0] = 16'd0; img[1] = 16'd4; img[2] = 16'h800A;
    img[3] = 16'd0; img[4] = 16'h8014; img[5] = 16'h800B;
    img[10] = 16'hFFFE; img[11] = 16'h1111;
    run_case("R7 wrap exit", 1'b0);

    // R2 R3 R5 R6 R8: opcodes x register index pairs
    for (int o = 0; o < 4; o++)
      for (int d = 0; d < 8; d++)
        for (int s = 0; s < 8; s++) begin
          build_sweep(opl[o], 16'(d), 16'(s));
          run_case($sformatf("R5 op%0h d%0d s%0d", opl[o], d, s), 1'b0);
        end

    // R4: memory operands in and out of range, mixed with registers
    for (int o = 0; o < 2; o++)
      for (int d = 0; d < 6; d++)
        for (int s = 0; s < 6; s++) begin
          build_sweep(opl[o], opnd[d], opnd[s]);
          run_case($sformatf("R4 op%0h d%0h s%0h", opl[o], opnd[d], opnd[s]), 1'b0);
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule